// File: doc/BRIEF.md
# GPIO Bank Interrupt Controller with Per-Core Routing

This block is a bank of general-purpose pins, grouped into 8-pin ports, that sits behind a simple 32-bit register bus with byte enables. Software sets each pin's drive value and direction. It reads back either the driven value or the synchronised pad level. Each pin can be armed to record rising edges, falling edges or both into a sticky status bit, which software clears by writing ones.

A second chip-select opens a small window that holds one enable byte per port for each processor core. Every core gets its own level-high interrupt line. That line is asserted while any status bit that is enabled for that core is set, so pin interrupts can be spread across cores one line at a time. After reset, every implemented pin is enabled for every core.

The port bytes are placed in reversed order inside the shared 32-bit words. The two-bit edge-select fields are packed with their halfwords swapped. Driver software depends on these placements, so they are part of the behaviour.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, pinOut, pinDir, the status bits, the edge-select fields and cpuIrq are all zero, and every per-core enable byte of an implemented port reads 0xFF.
- R2: The data (word 0), direction (word 2, 1 = output) and status (word 3) registers hold port p in bits [8*(3-p)+7 : 8*(3-p)]. Pin i of port p is line 8*p+i on pinIn, pinOut and pinDir.
- R3: A read of the data word returns the written value for pins set as outputs and the level of pinIn for pins set as inputs, after a two-flop synchroniser.
- R4: The edge-select fields sit in words 4 and 5, which cover byte offsets 0 to 7. Port p takes the 16 bits that start at byte offset 2*(p XOR 1). Within that field, bit 2*i arms rising-edge capture for pin i and bit 2*i+1 arms falling-edge capture. A status bit is set only by an edge of an armed type, and a field of 00 never sets status.
- R5: Status bits stay set until a write to word 3 with a one in that bit position, in an enabled byte lane. If an armed edge sets a bit in the same cycle as a clear of that bit, the bit stays set.
- R6: In the per-core window, the enable byte for port p and core c is at byte offset (3-p)+4*c, which is word c, lane 3-p. cpuIrq[c] is the OR, over all lines, of the status bit ANDed with core c's enable bit.
- R7: cpuIrq is a registered level. It rises on the fourth rising clock edge after pinIn changes, and it stays high until the status is cleared or the enable is removed.
- R8: A write updates only the byte lanes whose busBe bit is set.
- R9: Byte lanes of unimplemented ports, unmapped words and core indices without a core read as zero. Writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mainSel | input | 1 | Selects the main register window |
| cpuSel | input | 1 | Selects the per-core enable window |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Word address within the selected window |
| busBe | input | 4 | Byte-lane write enables |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle as the select |
| pinIn | input | NUM_LINES | Pad input levels |
| pinOut | output | NUM_LINES | Pad drive values |
| pinDir | output | NUM_LINES | Pad output enables |
| cpuIrq | output | NUM_CPUS | Level-high interrupt, one per core |

## Verification
The bench uses the default build of 24 lines, two cores and two synchroniser stages. With three ports, the lane of port 3 in every one-bit register and the low half of the second edge-select word stay empty. This makes the zero readback and the ignored writes of R9 observable. With two cores, the bench can route one line to either core alone, to both or to neither, and check the set-versus-clear collision at the exact cycle it occurs.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;

  localparam int PORT_W    = 8;
  localparam int MAX_PORTS = 4;
  localparam int CPU_IDX_W = 2;

  typedef enum logic [2:0] {
    RD_NONE, RD_DATA, RD_DIR, RD_STAT, RD_MODE_LO, RD_MODE_HI, RD_CPU
  } rdSel_e;

  typedef struct packed {
    logic                 wrData;
    logic                 wrDir;
    logic                 wrStat;
    logic                 wrModeLo;
    logic                 wrModeHi;
    logic                 wrCpu;
    logic [CPU_IDX_W-1:0] cpuIdx;
    rdSel_e               rdSel;
    logic [3:0]           be;
    logic [31:0]          wdata;
  } strobes_t;

  // byte lane of port p in a one-bit-per-line register
  function automatic int laneOfPort(input int p);
    return (MAX_PORTS - 1) - p;
  endfunction

  // byte offset of port p across the two edge-select words
  function automatic int modeOffset(input int p);
    return 2 * (p ^ 1);
  endfunction

endpackage

// File: rtl/gpirq_ctrl.sv
module gpirq_ctrl
  import gpirq_pkg::*;
#(
  parameter int NUM_CPUS = 2
) (
  input  logic        mainSel,
  input  logic        cpuSel,
  input  logic        busWr,
  input  logic [2:0]  busAddr,
  input  logic [3:0]  busBe,
  input  logic [31:0] busWdata,
  output strobes_t    stb
);

  always_comb begin
    stb        = '0;
    stb.be     = busBe;
    stb.wdata  = busWdata;
    stb.cpuIdx = busAddr[CPU_IDX_W-1:0];
    stb.rdSel  = RD_NONE;
    if (mainSel) begin
      unique case (busAddr)
        3'd0: begin stb.wrData   = busWr; stb.rdSel = busWr ? RD_NONE : RD_DATA;    end
        3'd2: begin stb.wrDir    = busWr; stb.rdSel = busWr ? RD_NONE : RD_DIR;     end
        3'd3: begin stb.wrStat   = busWr; stb.rdSel = busWr ? RD_NONE : RD_STAT;    end
        3'd4: begin stb.wrModeLo = busWr; stb.rdSel = busWr ? RD_NONE : RD_MODE_LO; end
        3'd5: begin stb.wrModeHi = busWr; stb.rdSel = busWr ? RD_NONE : RD_MODE_HI; end
        default: ;
      endcase
    end else if (cpuSel && (int'(busAddr) < NUM_CPUS)) begin
      stb.wrCpu = busWr;
      stb.rdSel = busWr ? RD_NONE : RD_CPU;
    end
  end

endmodule

// File: rtl/gpirq_dpath.sv
module gpirq_dpath
  import gpirq_pkg::*;
#(
  parameter int NUM_LINES   = 24,
  parameter int NUM_CPUS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             stb,
  input  logic [NUM_LINES-1:0] pinIn,
  output logic [NUM_LINES-1:0] pinOut,
  output logic [NUM_LINES-1:0] pinDir,
  output logic [NUM_CPUS-1:0]  cpuIrq,
  output logic [31:0]          rdata
);

  localparam int NUM_PORTS = NUM_LINES / PORT_W;

  logic [NUM_PORTS-1:0][PORT_W-1:0]             outR, dirR, statR;
  logic [NUM_PORTS-1:0][2*PORT_W-1:0]           modeR;
  logic [NUM_CPUS-1:0][NUM_PORTS-1:0][PORT_W-1:0] enR;
  logic [NUM_CPUS-1:0][NUM_LINES-1:0]           enVec;

  logic [SYNC_STAGES-1:0][NUM_LINES-1:0] syncQ;
  logic [NUM_LINES-1:0] syncd, prevQ, rise, fall;
  logic [NUM_LINES-1:0] riseArm, fallArm, lineArmed, setVec, clrVec, statVec;
  logic unusedBits;

  assign unusedBits = ^{stb.be, stb.wdata};

  // input synchroniser and edge detect
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= '0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
      prevQ <= syncd;
    end
  end

  assign syncd     = syncQ[SYNC_STAGES-1];
  assign rise      = syncd & ~prevQ;
  assign fall      = ~syncd & prevQ;
  assign setVec    = (rise & riseArm) | (fall & fallArm);
  assign lineArmed = riseArm | fallArm;
  assign statVec   = statR;
  assign pinOut    = outR;
  assign pinDir    = dirR;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int L1 = laneOfPort(p);
    localparam int MO = modeOffset(p);
    localparam int MW = MO / 4;
    localparam int ML = MO % 4;
    logic modeHit;

    assign modeHit = (MW == 0) ? stb.wrModeLo : stb.wrModeHi;
    assign clrVec[PORT_W*p +: PORT_W] =
      (stb.wrStat && stb.be[L1]) ? stb.wdata[8*L1 +: 8] : '0;

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
      assign riseArm[PORT_W*p+i] = modeR[p][2*i];
      assign fallArm[PORT_W*p+i] = modeR[p][2*i+1];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        outR[p]  <= '0;
        dirR[p]  <= '0;
        statR[p] <= '0;
        modeR[p] <= '0;
      end else begin
        if (stb.wrData && stb.be[L1]) outR[p] <= stb.wdata[8*L1 +: 8];
        if (stb.wrDir  && stb.be[L1]) dirR[p] <= stb.wdata[8*L1 +: 8];
        if (modeHit && stb.be[ML])   modeR[p][7:0]  <= stb.wdata[8*ML +: 8];
        if (modeHit && stb.be[ML+1]) modeR[p][15:8] <= stb.wdata[8*(ML+1) +: 8];
        // a new edge outranks a clear in the same cycle
        statR[p] <= (statR[p] & ~clrVec[PORT_W*p +: PORT_W]) | setVec[PORT_W*p +: PORT_W];
      end
    end

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
      always_ff @(posedge clk) begin
        if (!rstN) enR[c][p] <= '1;
        else if (stb.wrCpu && (int'(stb.cpuIdx) == c) && stb.be[L1])
          enR[c][p] <= stb.wdata[8*L1 +: 8];
      end
    end
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_irq
    assign enVec[c] = enR[c];
    always_ff @(posedge clk) begin
      if (!rstN) cpuIrq[c] <= 1'b0;
      else       cpuIrq[c] <= |(statVec & enVec[c]);
    end
  end

  // readback
  always_comb begin
    rdata = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      unique case (stb.rdSel)
        RD_DATA: rdata[8*laneOfPort(p) +: 8] =
                   (dirR[p] & outR[p]) | (~dirR[p] & syncd[PORT_W*p +: PORT_W]);
        RD_DIR:  rdata[8*laneOfPort(p) +: 8] = dirR[p];
        RD_STAT: rdata[8*laneOfPort(p) +: 8] = statR[p];
        RD_MODE_LO: if (modeOffset(p) < 4) rdata[8*(modeOffset(p) % 4) +: 16] = modeR[p];
        RD_MODE_HI: if (modeOffset(p) >= 4) rdata[8*(modeOffset(p) % 4) +: 16] = modeR[p];
        RD_CPU: begin
          for (int c = 0; c < NUM_CPUS; c++)
            if (int'(stb.cpuIdx) == c) rdata[8*laneOfPort(p) +: 8] = enR[c][p];
        end
        default: ;
      endcase
    end
  end

  // a status bit can only appear on a line armed in the cycle before
  AST_STATUS_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    ((statVec & ~$past(statVec) & ~$past(lineArmed)) == '0)); // R4

  // a status bit can only drop after a clear write hit it
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (($past(statVec) & ~statVec & ~$past(clrVec)) == '0)); // R5

  // no pending status in the previous cycle means no interrupt now
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ($past(statVec) == '0) |-> (cpuIrq == '0)); // R7

endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpirq_pkg::*;
#(
  parameter int NUM_LINES   = 24,
  parameter int NUM_CPUS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 mainSel,
  input  logic                 cpuSel,
  input  logic                 busWr,
  input  logic [2:0]           busAddr,
  input  logic [3:0]           busBe,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [NUM_LINES-1:0] pinIn,
  output logic [NUM_LINES-1:0] pinOut,
  output logic [NUM_LINES-1:0] pinDir,
  output logic [NUM_CPUS-1:0]  cpuIrq
);

  localparam int NUM_PORTS = NUM_LINES / PORT_W;

  strobes_t stb;

  gpirq_ctrl #(.NUM_CPUS(NUM_CPUS)) u_ctrl (
    .mainSel (mainSel),
    .cpuSel  (cpuSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .busBe   (busBe),
    .busWdata(busWdata),
    .stb     (stb)
  );

  gpirq_dpath #(
    .NUM_LINES  (NUM_LINES),
    .NUM_CPUS   (NUM_CPUS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dpath (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .pinIn (pinIn),
    .pinOut(pinOut),
    .pinDir(pinDir),
    .cpuIrq(cpuIrq),
    .rdata (busRdata)
  );

  if (NUM_PORTS < MAX_PORTS) begin : g_unused_chk
    localparam int EMPTY_BITS = 8 * (MAX_PORTS - NUM_PORTS);
    always_comb begin
      if (rstN && (stb.rdSel inside {RD_DATA, RD_DIR, RD_STAT, RD_CPU}))
        AST_UNUSED_LANES_ZERO: assert (busRdata[EMPTY_BITS-1:0] == '0); // R9
    end
  end

endmodule

// File: tb/sim_gpio_irq_router.sv
`timescale 1ns/1ps
module sim_gpio_irq_router;

  localparam int NL = 24;
  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          mainSel = 1'b0, cpuSel = 1'b0, busWr = 1'b0;
  logic [2:0]    busAddr = '0;
  logic [3:0]    busBe = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NL-1:0] pinIn = '0;
  logic [NL-1:0] pinOut, pinDir;
  logic [NC-1:0] cpuIrq;

  int nTests = 0;
  int nFail  = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  gpio_irq_router #(.NUM_LINES(NL), .NUM_CPUS(NC), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .mainSel(mainSel), .cpuSel(cpuSel), .busWr(busWr),
    .busAddr(busAddr), .busBe(busBe), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinDir(pinDir), .cpuIrq(cpuIrq)
  );

  // {cpuWin, wordAddr, be, wdata, expected readback}
  localparam int NVEC = 11;
  localparam logic [71:0] VEC [NVEC] = '{
    {1'b0, 3'd2, 4'hF, 32'h12345678, 32'h12345600}, // R2 R9 direction, port 3 lane empty
    {1'b0, 3'd2, 4'h4, 32'hFFFFFFFF, 32'h12FF5600}, // R8 only lane 2
    {1'b0, 3'd2, 4'hF, 32'hFFFFFF00, 32'hFFFFFF00}, // R2 all outputs
    {1'b0, 3'd0, 4'hF, 32'hA5C3E7FF, 32'hA5C3E700}, // R3 outputs read back driven value
    {1'b0, 3'd4, 4'hF, 32'h89ABCDEF, 32'h89ABCDEF}, // R4 ports 0 and 1 fields
    {1'b0, 3'd5, 4'hF, 32'h12345678, 32'h12340000}, // R4 R9 port 3 half empty
    {1'b0, 3'd5, 4'h8, 32'hAB000000, 32'hAB340000}, // R8 single lane
    {1'b1, 3'd0, 4'hF, 32'h11223344, 32'h11223300}, // R6 core 0 enables
    {1'b1, 3'd1, 4'hF, 32'h55667788, 32'h55667700}, // R6 core 1 enables
    {1'b0, 3'd6, 4'hF, 32'hFFFFFFFF, 32'h00000000}, // R9 unmapped word
    {1'b1, 3'd2, 4'hF, 32'hFFFFFFFF, 32'h00000000}  // R9 no such core
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic cw, input logic [2:0] a, input logic [3:0] be,
                          input logic [31:0] d);
    @(negedge clk);
    mainSel = !cw; cpuSel = cw; busWr = 1'b1; busAddr = a; busBe = be; busWdata = d;
    @(negedge clk);
    mainSel = 1'b0; cpuSel = 1'b0; busWr = 1'b0; busBe = '0;
  endtask

  task automatic busRead(input logic cw, input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    mainSel = !cw; cpuSel = cw; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    mainSel = 1'b0; cpuSel = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #(200000 * 5);
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    waitCycles(3);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    busRead(1'b0, 3'd0, rd); check("R1 data", rd, 32'h0);
    busRead(1'b0, 3'd2, rd); check("R1 dir", rd, 32'h0);
    busRead(1'b0, 3'd3, rd); check("R1 status", rd, 32'h0);
    busRead(1'b0, 3'd4, rd); check("R1 mode lo", rd, 32'h0);
    busRead(1'b1, 3'd0, rd); check("R1 core0 enables", rd, 32'hFFFFFF00);
    busRead(1'b1, 3'd1, rd); check("R1 core1 enables", rd, 32'hFFFFFF00);
    check("R1 pins", {pinOut[15:0], pinDir[15:0]}, 32'h0);
    check("R1 irq", {30'b0, cpuIrq}, 32'h0);

    // table of write/readback vectors
    for (int k = 0; k < NVEC; k++) begin
      logic [71:0] v;
      v = VEC[k];
      busWrite(v[71], v[70:68], v[67:64], v[63:32]);
      busRead(v[71], v[70:68], rd);
      check($sformatf("R2/R4/R6/R8/R9 vector %0d", k), rd, v[31:0]);
    end
    check("R2 pinOut order", {8'h0, pinOut}, 32'h00E7C3A5);
    check("R2 pinDir", {8'h0, pinDir}, 32'h00FFFFFF);

    // back to a clean setup
    busWrite(1'b0, 3'd4, 4'hF, 32'h0);
    busWrite(1'b0, 3'd5, 4'hF, 32'h0);
    busWrite(1'b0, 3'd2, 4'hF, 32'h0);
    busWrite(1'b0, 3'd3, 4'hF, 32'hFFFFFFFF);
    busWrite(1'b1, 3'd0, 4'hF, 32'hFFFFFFFF);
    busWrite(1'b1, 3'd1, 4'hF, 32'hFFFFFFFF);

    // R3 inputs through the synchroniser; R4 unarmed lines set nothing
    @(negedge clk) pinIn = 24'h5A0F33;
    waitCycles(4);
    busRead(1'b0, 3'd0, rd); check("R3 input readback", rd, 32'h330F5A00);
    @(negedge clk) pinIn = '0;
    waitCycles(4);
    busRead(1'b0, 3'd3, rd); check("R4 mode 00 sets nothing", rd, 32'h0);

    // arm: line 3 rising, line 10 falling, line 17 both
    busWrite(1'b0, 3'd4, 4'hF, 32'h00400020);
    busWrite(1'b0, 3'd5, 4'hF, 32'h000C0000);

    // R7 latency of a rising edge on line 3
    @(negedge clk) pinIn[3] = 1'b1;
    waitCycles(3);
    #1 check("R7 irq not yet at edge 3", {30'b0, cpuIrq}, 32'h0);
    @(posedge clk);
    #1 check("R7 irq at edge 4", {30'b0, cpuIrq}, 32'h3);
    busRead(1'b0, 3'd3, rd); check("R4 rising line 3", rd, 32'h08000000);
    @(negedge clk) pinIn[3] = 1'b0;
    waitCycles(10);
    busRead(1'b0, 3'd3, rd); check("R4 falling not armed line 3", rd, 32'h08000000);
    check("R7 irq held", {30'b0, cpuIrq}, 32'h3);
    busWrite(1'b0, 3'd3, 4'hF, 32'h08000000);
    waitCycles(2);
    busRead(1'b0, 3'd3, rd); check("R5 clear", rd, 32'h0);
    check("R7 irq drops after clear", {30'b0, cpuIrq}, 32'h0);

    // line 10 falling only
    @(negedge clk) pinIn[10] = 1'b1;
    waitCycles(5);
    busRead(1'b0, 3'd3, rd); check("R4 rising not armed line 10", rd, 32'h0);
    @(negedge clk) pinIn[10] = 1'b0;
    waitCycles(5);
    busRead(1'b0, 3'd3, rd); check("R4 falling line 10", rd, 32'h00040000);

    // line 17 both edges, lane-limited clear
    @(negedge clk) pinIn[17] = 1'b1;
    waitCycles(5);
    busRead(1'b0, 3'd3, rd); check("R4 both rising line 17", rd, 32'h00040200);
    busWrite(1'b0, 3'd3, 4'h4, 32'hFFFFFFFF);
    busRead(1'b0, 3'd3, rd); check("R5 R8 lane clear", rd, 32'h00000200);
    busWrite(1'b0, 3'd3, 4'hF, 32'h00000200);
    @(negedge clk) pinIn[17] = 1'b0;
    waitCycles(5);
    busRead(1'b0, 3'd3, rd); check("R4 both falling line 17", rd, 32'h00000200);

    // R6 per-core routing of line 17 (port 2 lane 1, pin 1)
    busWrite(1'b1, 3'd0, 4'h2, 32'h0);
    waitCycles(2);
    #1 check("R6 core1 only", {30'b0, cpuIrq}, 32'h2);
    busWrite(1'b1, 3'd1, 4'h2, 32'h0);
    waitCycles(2);
    #1 check("R6 neither core", {30'b0, cpuIrq}, 32'h0);
    busWrite(1'b1, 3'd0, 4'h2, 32'h00000100);
    waitCycles(2);
    #1 check("R6 other pin enabled", {30'b0, cpuIrq}, 32'h0);
    busWrite(1'b1, 3'd0, 4'h2, 32'h00000200);
    waitCycles(2);
    #1 check("R6 core0 only", {30'b0, cpuIrq}, 32'h1);

    // R5 set and clear in the same cycle: set wins
    @(negedge clk) pinIn[17] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    mainSel = 1'b1; busWr = 1'b1; busAddr = 3'd3; busBe = 4'hF; busWdata = 32'h00000200;
    @(negedge clk);
    mainSel = 1'b0; busWr = 1'b0; busBe = '0;
    busRead(1'b0, 3'd3, rd); check("R5 set beats clear", rd, 32'h00000200);
    busWrite(1'b0, 3'd3, 4'hF, 32'h00000200);
    busRead(1'b0, 3'd3, rd); check("R5 plain clear", rd, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule